// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Byte Queues

This block gives a processor an asynchronous serial link through ordinary loads and stores on its data bus. Software pushes bytes into a 16-entry transmit queue, then sets a send command bit. The transmitter drains the queue onto the serial output, one frame per byte. The receiver watches the serial input, rebuilds each frame and places the byte in a 16-entry receive queue. Software pops that queue by reading the receive window.

The bus side is a single synchronous port. A request is presented for one clock with a byte offset inside a 64-byte window. Read data appears on `bus_rdata` one clock later and holds until the next read. Offset bits 5:4 select one of four 16-byte regions: 0 is the transmit queue, 1 the receive queue, 2 the status word and 3 the configuration word. Bits 3:0 are not decoded. A level output follows the receive queue, so a processor can poll it or route it to its interrupt logic.

Configuration bits 14:0 hold a divisor D. An oversampling tick fires once every D+1 clocks, and one bit time is 16 ticks. Configuration bit 15 selects two stop bits when set.

Top module: `mmio_uart`

## Requirements
- R1: After reset the serial output is 1, `rx_ready` is 0, the status word reads 0 and the configuration word reads the parameter default divisor with bit 15 clear.
- R2: Each transmitted frame is one 0 bit, then 8 data bits least-significant first, then stop bits at 1. Every bit lasts 16*(D+1) clocks, and the line rests at 1 whenever no frame is in flight.
- R3: With configuration bit 15 clear, queued frames start exactly 160*(D+1) clocks apart. With it set, they start 176*(D+1) clocks apart.
- R4: A byte written to the transmit region stays queued and the line stays at 1 until software writes a 1 to status bit 0.
- R5: Status bit 0 (send command) reads 1 until the transmit queue is empty, then clears by itself. Status bit 1 (transmitter busy) reads 1 while a frame is on the line. Both read 0 once all frames have finished.
- R6: Status bit 4 reads 1 when the transmit queue holds 16 bytes. A write to the transmit region while the queue is full is dropped.
- R7: Received bytes are returned in arrival order by reads of the receive region, one byte per read. `rx_ready` and status bit 2 are 1 exactly while the receive queue is not empty.
- R8: A read of the receive region while the queue is empty returns 0.
- R9: A byte that completes while the receive queue is full is dropped and sets status bit 3. Bit 3 stays set until a status write with bit 3 at 1.
- R10: A received frame whose stop bit samples as 0 is dropped. The receiver still accepts the next well-formed frame.
- R11: A write to the configuration region stores all 16 bits, and a read returns them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus request valid this clock |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the 64-byte window |
| bus_wdata | input | 16 | Write data (bits 7:0 for queue writes) |
| bus_rdata | output | 16 | Read data, valid the clock after a read |
| uart_tx | output | 1 | Serial output |
| uart_rx | input | 1 | Serial input (asynchronous) |
| rx_ready | output | 1 | High while the receive queue holds data |

## Verification
The bench measures start-to-start spacing of queued frames for both stop settings. A transmitter that inserts an idle tick between frames, or ignores the stop selector, shows a spacing that is off by cycles. It fills both queues one entry past capacity. A design with an off-by-one full flag would send or return a seventeenth byte, or would lose the sixteenth. It sends a frame with a low stop bit and then a good frame. A receiver that skips the stop check would deliver the corrupt byte, and one that re-arms on a low line would produce a phantom byte or miss the next one. Empty reads and the sticky overflow bit are probed through the bus to catch a receiver that returns stale data or clears the flag on its own.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int unsigned OVERSAMPLE = 16;

  typedef enum logic [1:0] {
    RG_TXQ  = 2'd0,
    RG_RXQ  = 2'd1,
    RG_STAT = 2'd2,
    RG_CFG  = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  localparam int unsigned ST_GO    = 0;
  localparam int unsigned ST_BUSY  = 1;
  localparam int unsigned ST_AVAIL = 2;
  localparam int unsigned ST_OVF   = 3;
  localparam int unsigned ST_FULL  = 4;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [W-1:0]                   wdata,
  input  logic                           pop,
  output logic [W-1:0]                   rdata,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           full,
  output logic                           empty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/uart_tx_eng.sv
module uart_tx_eng (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       two_stop,
  input  logic       req,
  input  logic [7:0] data,
  output logic       take,
  output logic       busy,
  output logic       txd
);
  import uart_pkg::*;

  logic [10:0] sr_q, sr_d;
  logic [3:0]  left_q, left_d;
  logic [3:0]  ph_q, ph_d;
  logic        act_q, act_d;
  logic        last_tick, load;

  always_comb begin
    sr_d      = sr_q;
    left_d    = left_q;
    ph_d      = ph_q;
    act_d     = act_q;
    last_tick = act_q && (ph_q == 4'(OVERSAMPLE-1)) && (left_q == 4'd1);
    load      = tick && req && (!act_q || last_tick);
    if (load) begin
      sr_d   = {2'b11, data, 1'b0};
      left_d = two_stop ? 4'd11 : 4'd10;
      ph_d   = '0;
      act_d  = 1'b1;
    end else if (tick && act_q) begin
      if (ph_q == 4'(OVERSAMPLE-1)) begin
        sr_d   = {1'b1, sr_q[10:1]};
        left_d = left_q - 1'b1;
        ph_d   = '0;
        if (left_q == 4'd1) act_d = 1'b0;
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '1;
      left_q <= '0;
      ph_q   <= '0;
      act_q  <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      left_q <= left_d;
      ph_q   <= ph_d;
      act_q  <= act_d;
    end
  end

  assign take = load;
  assign busy = act_q;
  assign txd  = act_q ? sr_q[0] : 1'b1;
endmodule

// File: rtl/uart_rx_eng.sv
module uart_rx_eng (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  output logic       got_byte,
  output logic [7:0] data
);
  import uart_pkg::*;

  logic      s1_q, s2_q, prev_q, prev_d;
  rx_state_e st_q, st_d;
  logic [3:0] ph_q, ph_d;
  logic [2:0] idx_q, idx_d;
  logic [7:0] sr_q, sr_d;
  logic       mid;

  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    idx_d    = idx_q;
    sr_d     = sr_q;
    prev_d   = tick ? s2_q : prev_q;
    got_byte = 1'b0;
    mid      = (ph_q == 4'(OVERSAMPLE-1));
    if (tick) begin
      unique case (st_q)
        RX_IDLE: if (prev_q && !s2_q) begin
          st_d = RX_START;
          ph_d = '0;
        end
        RX_START: if (ph_q == 4'(OVERSAMPLE/2 - 1)) begin
          st_d  = s2_q ? RX_IDLE : RX_DATA;
          ph_d  = '0;
          idx_d = '0;
        end else ph_d = ph_q + 1'b1;
        RX_DATA: if (mid) begin
          sr_d  = {s2_q, sr_q[7:1]};
          ph_d  = '0;
          idx_d = idx_q + 1'b1;
          if (idx_q == 3'd7) st_d = RX_STOP;
        end else ph_d = ph_q + 1'b1;
        RX_STOP: if (mid) begin
          got_byte = s2_q;
          st_d     = RX_IDLE;
        end else ph_d = ph_q + 1'b1;
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      st_q   <= RX_IDLE;
      ph_q   <= '0;
      idx_q  <= '0;
      sr_q   <= '0;
    end else begin
      s1_q   <= rxd;
      s2_q   <= s1_q;
      prev_q <= prev_d;
      st_q   <= st_d;
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      sr_q   <= sr_d;
    end
  end

  assign data = sr_q;
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart #(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned DEF_DIV    = 324
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [5:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        uart_tx,
  input  logic        uart_rx,
  output logic        rx_ready
);
  import uart_pkg::*;

  localparam int unsigned CW = $clog2(FIFO_DEPTH+1);

  logic [15:0] cfg_q, cfg_d, rdata_q, rdata_d, status;
  logic [14:0] tdiv_q, tdiv_d;
  logic        tick, go_q, go_d, ovf_q, ovf_d;
  logic        wr, rd, wr_stat;
  region_e     region;
  logic [3:0]  unused_addr_bits;

  logic          tx_push, tx_full, tx_empty, tx_take, tx_busy;
  logic [7:0]    tx_head;
  logic [CW-1:0] tx_count;
  logic          rx_pop, rx_full, rx_empty, rx_got;
  logic [7:0]    rx_head, rx_byte;
  logic [CW-1:0] rx_count;

  assign unused_addr_bits = bus_addr[3:0];
  assign region  = region_e'(bus_addr[5:4]);
  assign wr      = bus_sel && bus_we;
  assign rd      = bus_sel && !bus_we;
  assign wr_stat = wr && (region == RG_STAT);
  assign tx_push = wr && (region == RG_TXQ);
  assign rx_pop  = rd && (region == RG_RXQ);
  assign tick    = (tdiv_q >= cfg_q[14:0]);

  assign status = {11'd0, tx_full, ovf_q, !rx_empty, tx_busy, go_q};

  always_comb begin
    tdiv_d  = tick ? '0 : tdiv_q + 1'b1;
    cfg_d   = (wr && region == RG_CFG) ? bus_wdata : cfg_q;
    go_d    = (wr_stat && bus_wdata[ST_GO]) ? 1'b1 : (tx_empty ? 1'b0 : go_q);
    ovf_d   = (rx_got && rx_full) || (ovf_q && !(wr_stat && bus_wdata[ST_OVF]));
    rdata_d = rdata_q;
    if (rd) begin
      unique case (region)
        RG_TXQ:  rdata_d = '0;
        RG_RXQ:  rdata_d = rx_empty ? '0 : {8'd0, rx_head};
        RG_STAT: rdata_d = status;
        RG_CFG:  rdata_d = cfg_q;
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdiv_q  <= '0;
      cfg_q   <= {1'b0, 15'(DEF_DIV)};
      go_q    <= 1'b0;
      ovf_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      tdiv_q  <= tdiv_d;
      cfg_q   <= cfg_d;
      go_q    <= go_d;
      ovf_q   <= ovf_d;
      rdata_q <= rdata_d;
    end
  end

  byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata[7:0]),
    .pop(tx_take), .rdata(tx_head), .count(tx_count),
    .full(tx_full), .empty(tx_empty)
  );

  byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_got), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_head), .count(rx_count),
    .full(rx_full), .empty(rx_empty)
  );

  uart_tx_eng u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .two_stop(cfg_q[15]),
    .req(go_q && !tx_empty), .data(tx_head), .take(tx_take),
    .busy(tx_busy), .txd(uart_tx)
  );

  uart_rx_eng u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(uart_rx),
    .got_byte(rx_got), .data(rx_byte)
  );

  assign bus_rdata = rdata_q;
  assign rx_ready  = !rx_empty;
endmodule

// File: rtl/mmio_uart_chk.sv
module mmio_uart_chk #(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [5:0]    bus_addr,
  input logic [15:0]   bus_wdata,
  input logic [15:0]   bus_rdata,
  input logic          uart_tx,
  input logic          rx_ready,
  input logic          tx_busy,
  input logic          go_q,
  input logic          ovf_q,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count
);
  logic stat_wr;
  assign stat_wr = bus_sel && bus_we && (bus_addr[5:4] == 2'd2);

  a_r2_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> uart_tx);

  a_r7_ready_tracks_queue: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready == (rx_count != '0));

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(stat_wr && bus_wdata[3])) |=> ovf_q);

  a_r4_go_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_q) |-> $past(stat_wr && bus_wdata[0]));

  a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr[5:4] == 2'd1 && rx_count == '0) |=> (bus_rdata == 16'd0));

  a_r6_tx_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(FIFO_DEPTH));
endmodule

bind mmio_uart mmio_uart_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .uart_tx(uart_tx), .rx_ready(rx_ready), .tx_busy(tx_busy),
  .go_q(go_q), .ovf_q(ovf_q), .rx_count(rx_count), .tx_count(tx_count)
);

// File: tb/mmio_uart_bench.sv
module mmio_uart_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        uart_tx, rx_ready;
  logic        uart_rx = 1'b1;

  int checks = 0, fails = 0;
  int div_cur = 324;
  int bt = 16 * 325;
  longint cyc = 0;
  longint prev_start = -1;
  int gap_exp = 0;
  bit gap_on = 1'b0;
  bit done = 1'b0;
  int tx_seen = 0;
  logic [7:0] tx_exp[$];
  logic [7:0] rx_exp[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  mmio_uart u_mmio_uart (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .uart_tx(uart_tx), .uart_rx(uart_rx), .rx_ready(rx_ready)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic set_cfg(logic [15:0] v);
    bus_wr(6'd48, v);
    div_cur = int'(v[14:0]);
    bt = 16 * (div_cur + 1);
  endtask

  // driver: push a byte to the transmit region, and to the scoreboard if expected
  task automatic tx_push(logic [7:0] b, logic [3:0] off, bit expect_it);
    bus_wr({2'b00, off}, {8'd0, b});
    if (expect_it) tx_exp.push_back(b);
  endtask

  task automatic wait_tx(int n);
    for (int k = 0; k < 40000 && tx_seen < n; k++) @(negedge clk);
    repeat (2 * bt) @(negedge clk);
  endtask

  // serial driver towards the receiver
  task automatic rx_send(logic [7:0] b, bit stop_ok, bit expect_it);
    @(negedge clk);
    uart_rx = 1'b0;
    repeat (bt) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      uart_rx = b[i];
      repeat (bt) @(negedge clk);
    end
    uart_rx = stop_ok;
    repeat (bt) @(negedge clk);
    uart_rx = 1'b1;
    repeat (bt) @(negedge clk);
    if (expect_it) rx_exp.push_back(b);
  endtask

  task automatic rx_read_check(string req);
    logic [15:0] d;
    logic [7:0] e;
    bus_rd(6'd16, d);
    e = (rx_exp.size() > 0) ? rx_exp.pop_front() : 8'd0;
    check(d == {8'd0, e}, req, d, e);
  endtask

  // monitor: decode serial frames and compare against the scoreboard
  initial begin
    forever begin
      logic [7:0] got, e;
      logic b0, stp;
      @(negedge uart_tx);
      if (gap_on && prev_start >= 0)
        check((cyc - prev_start) == gap_exp, "R3 frame spacing", cyc - prev_start, gap_exp);
      prev_start = cyc;
      repeat (bt / 2) @(negedge clk);
      b0 = uart_tx;
      for (int i = 0; i < 8; i++) begin
        repeat (bt) @(negedge clk);
        got[i] = uart_tx;
      end
      repeat (bt) @(negedge clk);
      stp = uart_tx;
      e = (tx_exp.size() > 0) ? tx_exp.pop_front() : 8'hxx;
      check(b0 == 1'b0 && stp == 1'b1, "R2 start/stop levels", {b0, stp}, 2'b01);
      check(got === e, "R2 data bits", got, e);
      tx_seen++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check(uart_tx == 1'b1, "R1 tx idle", uart_tx, 1);
    check(rx_ready == 1'b0, "R1 rx_ready", rx_ready, 0);
    bus_rd(6'd32, d);
    check(d == 16'd0, "R1 status", d, 0);
    bus_rd(6'd48, d);
    check(d == 16'd324, "R1 config default", d, 16'd324);

    // R11 configuration write and read back
    set_cfg(16'h8000);
    bus_rd(6'd52, d);
    check(d == 16'h8000, "R11 config readback", d, 16'h8000);
    set_cfg(16'h0000);
    bus_rd(6'd48, d);
    check(d == 16'h0000, "R11 config readback zero", d, 0);

    // R4 nothing leaves before the send command
    tx_push(8'h55, 4'd0, 1'b1);
    tx_push(8'hA3, 4'd5, 1'b1);
    tx_push(8'h01, 4'd15, 1'b1);
    repeat (5 * bt) @(negedge clk);
    check(tx_seen == 0, "R4 no frame before command", tx_seen, 0);
    check(uart_tx == 1'b1, "R4 line held idle", uart_tx, 1);

    // R5 command and busy bits
    bus_wr(6'd32, 16'h0001);
    repeat (3) @(negedge clk);
    bus_rd(6'd32, d);
    check(d[1:0] == 2'b11, "R5 command and busy set", d[1:0], 3);
    wait_tx(3);
    check(tx_seen == 3, "R2 three frames", tx_seen, 3);
    bus_rd(6'd32, d);
    check(d[1:0] == 2'b00, "R5 command and busy clear", d[1:0], 0);

    // R3 spacing with two stop bits, then one
    set_cfg(16'h8000);
    prev_start = -1; gap_exp = 176; gap_on = 1'b1;
    tx_push(8'h3E, 4'd0, 1'b1);
    tx_push(8'hC1, 4'd0, 1'b1);
    bus_wr(6'd32, 16'h0001);
    wait_tx(5);
    set_cfg(16'h0000);
    prev_start = -1; gap_exp = 160;
    tx_push(8'h99, 4'd0, 1'b1);
    tx_push(8'h66, 4'd0, 1'b1);
    bus_wr(6'd32, 16'h0001);
    wait_tx(7);
    gap_on = 1'b0;

    // R2 with a slower divisor
    set_cfg(16'h0001);
    tx_push(8'hC6, 4'd0, 1'b1);
    bus_wr(6'd32, 16'h0001);
    wait_tx(8);
    check(tx_seen == 8, "R2 divisor one frame", tx_seen, 8);
    set_cfg(16'h0000);

    // R6 full queue and dropped write
    base = tx_seen;
    for (int i = 0; i < 17; i++) tx_push(8'(8'h10 + i), 4'd0, i < 16);
    bus_rd(6'd32, d);
    check(d[4] == 1'b1, "R6 full flag", d[4], 1);
    bus_wr(6'd32, 16'h0001);
    wait_tx(base + 16);
    repeat (12 * bt) @(negedge clk);
    check(tx_seen == base + 16, "R6 extra byte dropped", tx_seen, base + 16);
    bus_rd(6'd32, d);
    check(d[4] == 1'b0, "R6 full flag cleared", d[4], 0);

    // R7 reception order and ready level
    rx_send(8'h3C, 1'b1, 1'b1);
    rx_send(8'hE1, 1'b1, 1'b1);
    check(rx_ready == 1'b1, "R7 rx_ready high", rx_ready, 1);
    bus_rd(6'd32, d);
    check(d[2] == 1'b1, "R7 status available", d[2], 1);
    rx_read_check("R7 first byte");
    rx_read_check("R7 second byte");
    @(negedge clk);
    check(rx_ready == 1'b0, "R7 rx_ready low", rx_ready, 0);

    // R8 empty read
    rx_read_check("R8 empty read returns zero");

    // R10 framing error then recovery
    rx_send(8'h5A, 1'b0, 1'b0);
    check(rx_ready == 1'b0, "R10 bad frame dropped", rx_ready, 0);
    bus_rd(6'd32, d);
    check(d[2] == 1'b0, "R10 status not available", d[2], 0);
    rx_send(8'h77, 1'b1, 1'b1);
    rx_read_check("R10 next frame accepted");

    // R9 overflow
    for (int i = 0; i < 17; i++) rx_send(8'(8'hA0 + i), 1'b1, i < 16);
    bus_rd(6'd32, d);
    check(d[3] == 1'b1, "R9 overflow set", d[3], 1);
    bus_wr(6'd32, 16'h0000);
    bus_rd(6'd32, d);
    check(d[3] == 1'b1, "R9 overflow sticky", d[3], 1);
    for (int i = 0; i < 16; i++) rx_read_check("R9 retained bytes");
    rx_read_check("R9 seventeenth byte absent");
    bus_wr(6'd32, 16'h0008);
    bus_rd(6'd32, d);
    check(d[3] == 1'b0, "R9 overflow cleared", d[3], 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule